// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Store-Driven Line Invalidation

This block sits between an instruction fetch port and a backing memory read port. It holds `LINES` lines of one 32-bit word each, with the line index taken from the low bits of the word address and the tag from the bits above it. With the cache on, a fetch that hits is answered in the same cycle. A fetch that misses stalls while a single-word read goes to memory. The returned word is then written into the line and handed to the fetch port in the cycle it arrives.

A 2-bit mode input selects how the cache behaves. In invalidate mode the cache watches every data-side store. It uses the low index bits of the store's write data as a line number and clears that line's valid bit, whatever the store address is. The store itself is always passed on to the memory write port unchanged. Software clears the whole cache by storing the values 0 up to `LINES-1` on consecutive cycles. In the off mode and the reserved mode, fetches go straight to memory and the line state is not touched.

The controller has three states. `ST_IDLE` answers hits. It takes transition *miss* to `ST_FILL` when the mode is on and the lookup misses, and transition *bypass* to `ST_PASS` for any fetch made in another mode. `ST_FILL` takes transition *refill done* back to `ST_IDLE` when memory acknowledges, and writes the line in that cycle. `ST_PASS` takes transition *pass done* back to `ST_IDLE` when memory acknowledges, and allocates nothing.

Top module: `icw_icache`

## Requirements
- R1: Reset clears every valid bit. After reset, the first fetch to any address with the mode on raises `mem_rd_req_o` and is not acknowledged in its request cycle.
- R2: With mode 2'b10 (on), a fetch whose line is valid with a matching tag is acknowledged in the same cycle as the request, with the stored word, and no memory read is made.
- R3: With the mode on, a missing fetch holds `mem_rd_req_o` high, with `mem_rd_addr_o` equal to the fetch word address, until `mem_rd_ack_i`. In that cycle `fetch_ack_o` rises with `fetch_data_o` equal to `mem_rd_data_i`, and the line then holds that word under the new tag.
- R4: With mode 2'b01 (invalidate), a store clears the valid bit of the line whose index equals `st_data_i[IDX_W-1:0]`, whatever `st_addr_i` is. A later fetch to that line with the mode on misses.
- R5: In every mode, `mem_wr_o`, `mem_wr_addr_o` and `mem_wr_data_o` equal `st_valid_i`, `st_addr_i` and `st_data_i` in the same cycle.
- R6: Stores on consecutive cycles in invalidate mode each clear their line. A sweep of the values 0 to `LINES-1` leaves no line that can hit.
- R7: With mode 2'b00 (off) or 2'b11 (reserved), each fetch is served from memory as in R3 but allocates nothing. Lines filled earlier still hit afterwards.
- R8: With the invalidate mode, fetches are also served from memory and allocate nothing.
- R9: Stores made with the mode on or off leave every valid bit unchanged.
- R10: If an invalidating store names the same line that a refill writes in the same cycle, the line ends up invalid.
- R11: A fetch with the mode on to a valid line whose tag differs misses. The refill then replaces the old tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 off, 01 invalidate, 10 on, 11 reserved (acts as off) |
| fetch_req_i | input | 1 | Fetch request, held until acknowledged |
| fetch_addr_i | input | WADDR_W | Fetch word address, held with the request |
| fetch_ack_o | output | 1 | Fetch completes this cycle |
| fetch_data_o | output | DATA_W | Fetched instruction word |
| mem_rd_req_o | output | 1 | Memory read request |
| mem_rd_addr_o | output | WADDR_W | Memory read word address |
| mem_rd_ack_i | input | 1 | Memory read data valid, one cycle |
| mem_rd_data_i | input | DATA_W | Memory read data |
| st_valid_i | input | 1 | Data-side store strobe |
| st_addr_i | input | WADDR_W | Store word address |
| st_data_i | input | DATA_W | Store write data; low index bits name a line in invalidate mode |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wr_addr_o | output | WADDR_W | Memory write word address |
| mem_wr_data_o | output | DATA_W | Memory write data |

## Verification
The bench builds the block with its default parameters: 256 lines, 30-bit word addresses and 32-bit data. With these values the full back-to-back invalidation sweep over every index runs within the cycle limit. Random fetches are drawn from 16 indices and 4 tags, so hits, tag conflicts and replacements happen often. The random mix also covers mode changes and memory latencies of 0 to 3 cycles. A directed step lines up an invalidating store with the acknowledge cycle of a refill to the same index.

// File: rtl/icw_pkg.sv
package icw_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_INVAL = 2'b01,
        MODE_ON    = 2'b10,
        MODE_RSVD  = 2'b11
    } icw_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_PASS
    } icw_state_e;

endpackage

// File: rtl/icw_line_store.sv
module icw_line_store #(
    parameter int LINES   = 256,
    parameter int WADDR_W = 30,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = $clog2(LINES),
    localparam int TAG_W  = WADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx_i,
    input  logic [TAG_W-1:0]  rd_tag_i,
    output logic              hit_o,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              fill_we_i,
    input  logic [IDX_W-1:0]  fill_idx_i,
    input  logic [TAG_W-1:0]  fill_tag_i,
    input  logic [DATA_W-1:0] fill_data_i,
    input  logic              inv_we_i,
    input  logic [IDX_W-1:0]  inv_idx_i
);

    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    // Valid bits: an invalidation in the same cycle overrides a fill.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (fill_we_i) valid_q[fill_idx_i] <= 1'b1;
            if (inv_we_i)  valid_q[inv_idx_i]  <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_we_i) begin
            tag_q[fill_idx_i]  <= fill_tag_i;
            data_q[fill_idx_i] <= fill_data_i;
        end
    end

    assign hit_o     = valid_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);
    assign rd_data_o = data_q[rd_idx_i];

    // R4
    inval_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_we_i |=> !valid_q[$past(inv_idx_i)]);

    // R3
    fill_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_we_i && !(inv_we_i && inv_idx_i == fill_idx_i))
        |=> (valid_q[$past(fill_idx_i)] && tag_q[$past(fill_idx_i)] == $past(fill_tag_i)));

endmodule

// File: rtl/icw_fsm.sv
module icw_fsm
    import icw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  icw_mode_e mode_i,
    input  logic      fetch_req_i,
    input  logic      hit_i,
    input  logic      mem_rd_ack_i,
    output logic      fetch_ack_o,
    output logic      mem_rd_req_o,
    output logic      fill_we_o,
    output logic      use_mem_o
);

    icw_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d      = state_q;
        fetch_ack_o  = 1'b0;
        mem_rd_req_o = 1'b0;
        fill_we_o    = 1'b0;
        use_mem_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (fetch_req_i) begin
                    if (mode_i == MODE_ON) begin
                        if (hit_i) fetch_ack_o = 1'b1;
                        else       state_d     = ST_FILL;
                    end else begin
                        state_d = ST_PASS;
                    end
                end
            end
            ST_FILL: begin
                mem_rd_req_o = 1'b1;
                if (mem_rd_ack_i) begin
                    fill_we_o   = 1'b1;
                    fetch_ack_o = 1'b1;
                    use_mem_o   = 1'b1;
                    state_d     = ST_IDLE;
                end
            end
            ST_PASS: begin
                mem_rd_req_o = 1'b1;
                if (mem_rd_ack_i) begin
                    fetch_ack_o = 1'b1;
                    use_mem_o   = 1'b1;
                    state_d     = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R2
    hit_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && fetch_ack_o) |-> (mode_i == MODE_ON && !mem_rd_req_o));

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req_o && !mem_rd_ack_i) |=> mem_rd_req_o);

    // R7
    pass_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PASS) |-> !fill_we_o);

endmodule

// File: rtl/icw_icache.sv
module icw_icache
    import icw_pkg::*;
#(
    parameter int LINES   = 256,
    parameter int WADDR_W = 30,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode_i,
    input  logic               fetch_req_i,
    input  logic [WADDR_W-1:0] fetch_addr_i,
    output logic               fetch_ack_o,
    output logic [DATA_W-1:0]  fetch_data_o,
    output logic               mem_rd_req_o,
    output logic [WADDR_W-1:0] mem_rd_addr_o,
    input  logic               mem_rd_ack_i,
    input  logic [DATA_W-1:0]  mem_rd_data_i,
    input  logic               st_valid_i,
    input  logic [WADDR_W-1:0] st_addr_i,
    input  logic [DATA_W-1:0]  st_data_i,
    output logic               mem_wr_o,
    output logic [WADDR_W-1:0] mem_wr_addr_o,
    output logic [DATA_W-1:0]  mem_wr_data_o
);

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = WADDR_W - IDX_W;

    icw_mode_e         mode;
    logic              hit, fill_we, use_mem, inv_we;
    logic [DATA_W-1:0] line_data;
    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;

    assign mode   = icw_mode_e'(mode_i);
    assign idx    = fetch_addr_i[IDX_W-1:0];
    assign tag    = fetch_addr_i[WADDR_W-1:IDX_W];
    assign inv_we = st_valid_i && (mode == MODE_INVAL);

    icw_line_store #(
        .LINES   (LINES),
        .WADDR_W (WADDR_W),
        .DATA_W  (DATA_W)
    ) store_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_idx_i    (idx),
        .rd_tag_i    (tag),
        .hit_o       (hit),
        .rd_data_o   (line_data),
        .fill_we_i   (fill_we),
        .fill_idx_i  (idx),
        .fill_tag_i  (tag),
        .fill_data_i (mem_rd_data_i),
        .inv_we_i    (inv_we),
        .inv_idx_i   (st_data_i[IDX_W-1:0])
    );

    icw_fsm fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode),
        .fetch_req_i  (fetch_req_i),
        .hit_i        (hit),
        .mem_rd_ack_i (mem_rd_ack_i),
        .fetch_ack_o  (fetch_ack_o),
        .mem_rd_req_o (mem_rd_req_o),
        .fill_we_o    (fill_we),
        .use_mem_o    (use_mem)
    );

    assign fetch_data_o  = use_mem ? mem_rd_data_i : line_data;
    assign mem_rd_addr_o = fetch_addr_i;

    // Stores always reach memory; the cache only watches them.
    assign mem_wr_o      = st_valid_i;
    assign mem_wr_addr_o = st_addr_i;
    assign mem_wr_data_o = st_data_i;

    // R3
    rd_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req_o && !mem_rd_ack_i) |=> $stable(mem_rd_addr_o));

endmodule

// File: tb/icw_icache_tb_top.sv
module icw_icache_tb_top;
    import icw_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = MODE_ON;
    logic        fetch_req = 1'b0;
    logic [29:0] fetch_addr = '0;
    logic        fetch_ack_o;
    logic [31:0] fetch_data_o;
    logic        mem_rd_req_o;
    logic [29:0] mem_rd_addr_o;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_data = '0;
    logic        st_valid = 1'b0;
    logic [29:0] st_addr = '0;
    logic [31:0] st_data = '0;
    logic        mem_wr_o;
    logic [29:0] mem_wr_addr_o;
    logic [31:0] mem_wr_data_o;

    always #2 clk = ~clk;

    icw_icache dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .fetch_req_i(fetch_req), .fetch_addr_i(fetch_addr),
        .fetch_ack_o(fetch_ack_o), .fetch_data_o(fetch_data_o),
        .mem_rd_req_o(mem_rd_req_o), .mem_rd_addr_o(mem_rd_addr_o),
        .mem_rd_ack_i(mem_ack), .mem_rd_data_i(mem_data),
        .st_valid_i(st_valid), .st_addr_i(st_addr), .st_data_i(st_data),
        .mem_wr_o(mem_wr_o), .mem_wr_addr_o(mem_wr_addr_o), .mem_wr_data_o(mem_wr_data_o)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    bit          ref_v [256];
    logic [21:0] ref_t [256];
    logic [31:0] ref_d [256];
    logic [31:0] epoch = 32'h0;

    function automatic logic [31:0] memval(input logic [29:0] wa, input logic [31:0] ep);
        return {wa, 2'b01} ^ 32'h5A5A_1234 ^ (ep * 32'h0101_0007);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // One fetch; clash lines up an invalidating store with the refill acknowledge (R10).
    task automatic do_fetch(input logic [29:0] wa, input int lat, input bit clash);
        logic [7:0] ix;
        bit         exp_hit;
        logic [1:0] m;
        logic [31:0] v;
        ix = wa[7:0];
        m = mode;
        exp_hit = (m == MODE_ON) && ref_v[ix] && (ref_t[ix] == wa[29:8]);
        @(negedge clk);
        fetch_req = 1'b1;
        fetch_addr = wa;
        #1;
        if (exp_hit) begin
            chk(fetch_ack_o == 1'b1, "R2 hit ack same cycle", 64'(fetch_ack_o), 64'd1);
            chk(fetch_data_o == ref_d[ix], "R2 hit data", 64'(fetch_data_o), 64'(ref_d[ix]));
            chk(mem_rd_req_o == 1'b0, "R2 no memory read on hit", 64'(mem_rd_req_o), 64'd0);
            @(negedge clk);
            fetch_req = 1'b0;
        end else begin
            chk(fetch_ack_o == 1'b0, "R1 R11 R7 no ack in request cycle", 64'(fetch_ack_o), 64'd0);
            @(negedge clk);
            chk(mem_rd_req_o == 1'b1, "R3 R7 R8 memory read raised", 64'(mem_rd_req_o), 64'd1);
            chk(mem_rd_addr_o == wa, "R3 memory read address", 64'(mem_rd_addr_o), 64'(wa));
            repeat (lat) @(negedge clk);
            v = memval(wa, epoch);
            mem_ack = 1'b1;
            mem_data = v;
            if (clash) begin
                mode = MODE_INVAL;
                st_valid = 1'b1;
                st_data = {24'h0, ix};
            end
            #1;
            chk(fetch_ack_o == 1'b1, "R3 ack with memory data", 64'(fetch_ack_o), 64'd1);
            chk(fetch_data_o == v, "R3 refill data", 64'(fetch_data_o), 64'(v));
            @(negedge clk);
            mem_ack = 1'b0;
            fetch_req = 1'b0;
            if (clash) begin
                st_valid = 1'b0;
                mode = m;
                ref_v[ix] = 1'b0;
            end else if (m == MODE_ON) begin
                ref_v[ix] = 1'b1;
                ref_t[ix] = wa[29:8];
                ref_d[ix] = v;
            end
        end
    endtask

    // Drives one store cycle and leaves the strobe up; st_end drops it.
    task automatic do_store(input logic [29:0] a, input logic [31:0] d);
        @(negedge clk);
        st_valid = 1'b1;
        st_addr = a;
        st_data = d;
        #1;
        chk(mem_wr_o == 1'b1 && mem_wr_addr_o == a && mem_wr_data_o == d,
            "R5 store forwarded", {mem_wr_addr_o, mem_wr_data_o}, {a, d});
        if (mode == MODE_INVAL) ref_v[d[7:0]] = 1'b0;
    endtask

    task automatic st_end();
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    function automatic logic [29:0] pool_addr();
        logic [29:0] a;
        a = {20'h0, 2'(($urandom % 4)), 8'(($urandom % 16))};
        return a;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired act=1 exp=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 256; i++) ref_v[i] = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(fetch_ack_o == 1'b0 && mem_rd_req_o == 1'b0, "R1 reset outputs idle",
            {fetch_ack_o, mem_rd_req_o}, 64'd0);
        rst_n = 1'b1;

        // R1: every first fetch misses after reset
        mode = MODE_ON;
        for (int i = 0; i < 8; i++) do_fetch(30'(i * 37 + 5), i % 3, 1'b0);
        for (int i = 0; i < 8; i++) do_fetch(30'(i * 37 + 5), 0, 1'b0);   // R2 hits

        // R11: same index, different tag
        do_fetch(30'h0000_0105, 1, 1'b0);
        do_fetch(30'h0000_0105, 0, 1'b0);
        do_fetch(30'h0000_0005, 2, 1'b0);

        // R9: stores with mode on / off do not invalidate
        do_store(30'h123, 32'h0000_002A); st_end();
        mode = MODE_OFF;
        do_store(30'h124, 32'h0000_0005); st_end();
        mode = MODE_ON;
        do_fetch(30'h0000_0005, 0, 1'b0);
        do_fetch(30'(1 * 37 + 5), 0, 1'b0);

        // R7: off and reserved modes bypass and allocate nothing
        mode = MODE_OFF;
        do_fetch(30'h0000_0005, 1, 1'b0);
        do_fetch(30'h0000_0077, 0, 1'b0);
        mode = MODE_RSVD;
        do_fetch(30'h0000_0078, 2, 1'b0);
        mode = MODE_ON;
        do_fetch(30'h0000_0005, 0, 1'b0);
        do_fetch(30'h0000_0077, 1, 1'b0);

        // R4 R8: invalidate selected indices, other lines still hit
        mode = MODE_INVAL;
        do_fetch(30'h0000_0079, 0, 1'b0);
        do_store(30'h3FF_0000, 32'h0000_002A); st_end();
        do_store(30'h0000_0000, 32'hFFFF_FF05); st_end();
        mode = MODE_ON;
        do_fetch(30'h0000_0079, 0, 1'b0);
        do_fetch(30'h0000_0005, 1, 1'b0);
        do_fetch(30'(42), 0, 1'b0);
        do_fetch(30'(79), 0, 1'b0);

        // R10: invalidation wins over same-cycle refill
        do_fetch(30'h0000_0533, 2, 1'b1);
        do_fetch(30'h0000_0533, 0, 1'b0);
        do_fetch(30'h0000_0533, 0, 1'b0);

        // R6: back-to-back sweep over every index
        mode = MODE_INVAL;
        for (int i = 0; i < 256; i++) do_store(30'h10, 32'(i));
        st_end();
        mode = MODE_ON;
        for (int i = 0; i < 256; i++)
            chk(ref_v[i] == 1'b0, "R6 model cleared", 64'(ref_v[i]), 64'd0);
        for (int i = 0; i < 8; i++) do_fetch(30'(i * 37 + 5), 0, 1'b0);
        do_fetch(30'h0000_0533, 1, 1'b0);

        // Random mix
        for (int n = 0; n < 1500; n++) begin
            int r;
            r = int'($urandom % 12);
            if (r < 7) begin
                do_fetch(pool_addr(), int'($urandom % 4), 1'b0);
            end else if (r < 9) begin
                do_store(30'($urandom), {$urandom} & 32'hFFFF_FF0F); st_end();
            end else if (r < 11) begin
                case ($urandom % 6)
                    0: mode = MODE_OFF;
                    1: mode = MODE_INVAL;
                    2: mode = MODE_RSVD;
                    default: mode = MODE_ON;
                endcase
            end else begin
                epoch = epoch + 1;
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule